// File: doc/BRIEF.md
# Conversion Result Bank with Pending Flags

This block holds the results of an analog-to-digital converter. It has sixteen slots, and each slot keeps one 12-bit result. Each slot also has a pending flag and an enable bit. The conversion sequencer writes results through a load port: it gives a slot number and a value. Each load sets the pending flag of that slot.

The processor reaches the block through a plain register bus with a select, a write strobe and an address. Results are read back zero-extended to 16 bits. Reading a result slot clears that slot's pending flag. This lets an interrupt handler acknowledge a result simply by fetching it. The flag word and the enable word are two more bus registers. Writing the flag word replaces its contents.

All slots share one interrupt request line. It is raised while any slot is both pending and enabled. A second output gives the lowest such slot, encoded as slot number plus one, with zero meaning nothing is pending. The bus decode sorts each access into one of four kinds: result, flag, enable or none.

Top module: `conv_result_bank`

## Requirements
- R1: After reset, every result reads 0, the flag word and the enable word read 0, `irq` is 0 and `irq_idx` is 0.
- R2: A load with `ld_en`=1 stores `ld_data` in slot `ld_slot`. A read of address 0..15 returns that slot's value in bits 11:0, with bits 15:12 reading as 0. Read data is combinational in the cycle of the access.
- R3: A load sets bit `ld_slot` of the flag word (address 16, bit i belongs to slot i). No flag bit becomes set except through a load or a flag-word write.
- R4: A read of result address i clears flag bit i at the end of that cycle. Reads of the flag word or the enable word clear nothing.
- R5: When a load and a read of the same slot fall in the same cycle, the read returns the old value and the flag stays set.
- R6: A write to address 16 replaces the flag word with `bus_wdata`. A load in the same cycle still sets its own bit.
- R7: The enable word sits at address 17 and is written directly. `irq` is the OR over all slots of flag AND enable, so an enable of 0 masks that slot.
- R8: `irq_idx` is one plus the lowest slot that is both pending and enabled, and 0 when there is no such slot.
- R9: Writes to result addresses change nothing. Reads of addresses 18..31 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_en | input | 1 | Result load strobe from the sequencer |
| ld_slot | input | 4 | Slot to load |
| ld_data | input | 12 | Result value to load |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| irq | output | 1 | Shared interrupt request |
| irq_idx | output | 5 | Lowest pending enabled slot plus one, 0 if none |

## Verification
The bench drives a load and a read of the same slot in one cycle. A design that let the read win would drop a fresh flag and lose an interrupt. It also writes the flag word while a load is in flight, which catches a design that lets the write wipe out the new bit. It reads the flag and enable words repeatedly to expose a read-clear that fires on the wrong address. It then moves the enables around two pending slots so that the index must switch between them, which catches a priority encoder that picks the highest slot or ignores the mask.

// File: rtl/crb_pkg.sv
package crb_pkg;
    typedef enum logic [1:0] {
        ACC_RESULT = 2'd0,
        ACC_FLAG   = 2'd1,
        ACC_ENABLE = 2'd2,
        ACC_NONE   = 2'd3
    } acc_kind_e;
endpackage

// File: rtl/crb_slot_store.sv
module crb_slot_store #(
    parameter int NUM_SLOTS = 16,
    parameter int RES_W     = 12,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SLOTS-1:0] ld_vec,
    input  logic [RES_W-1:0]  ld_data,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [RES_W-1:0]  rd_val
);
    logic [RES_W-1:0] slot_q [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (ld_vec[g])
                slot_q[g] <= ld_data;
        end
    end

    assign rd_val = slot_q[rd_slot];
endmodule

// File: rtl/crb_flag_ctrl.sv
module crb_flag_ctrl #(
    parameter int NUM_SLOTS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] ld_vec,
    input  logic [NUM_SLOTS-1:0] rd_clr_vec,
    input  logic                 flag_wr,
    input  logic                 en_wr,
    input  logic [NUM_SLOTS-1:0] wr_val,
    output logic [NUM_SLOTS-1:0] flags_q,
    output logic [NUM_SLOTS-1:0] en_q
);
    logic [NUM_SLOTS-1:0] flags_d;

    always_comb begin
        if (flag_wr)
            flags_d = wr_val;
        else
            flags_d = flags_q & ~rd_clr_vec;
        flags_d = flags_d | ld_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            en_q    <= '0;
        end else begin
            flags_q <= flags_d;
            if (en_wr)
                en_q <= wr_val;
        end
    end

    AST_LOAD_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (|ld_vec) |=> ((flags_q & $past(ld_vec)) == $past(ld_vec))); // R3

    AST_READ_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ((|rd_clr_vec) && !flag_wr) |=> ((flags_q & $past(rd_clr_vec & ~ld_vec)) == '0)); // R4

    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_wr |=> ((flags_q & ~$past(flags_q) & ~$past(ld_vec)) == '0)); // R3

    AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en_wr |=> $stable(en_q)); // R7
endmodule

// File: rtl/crb_prio_idx.sv
module crb_prio_idx #(
    parameter int NUM_SLOTS = 16,
    localparam int IDX_W    = $clog2(NUM_SLOTS) + 1
) (
    input  logic [NUM_SLOTS-1:0] pend,
    output logic [IDX_W-1:0]     idx
);
    always_comb begin
        idx = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (pend[i])
                idx = IDX_W'(i + 1);
        end
    end
endmodule

// File: rtl/conv_result_bank.sv
module conv_result_bank
    import crb_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int RES_W     = 12,
    parameter int DATA_W    = 16,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int ADDR_W   = SLOT_W + 1,
    localparam int IDX_W    = SLOT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [SLOT_W-1:0] ld_slot,
    input  logic [RES_W-1:0]  ld_data,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic [IDX_W-1:0]  irq_idx
);
    localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(NUM_SLOTS);
    localparam logic [ADDR_W-1:0] EN_ADDR   = ADDR_W'(NUM_SLOTS + 1);

    acc_kind_e            acc_kind;
    logic [NUM_SLOTS-1:0] ld_vec;
    logic [NUM_SLOTS-1:0] rd_clr_vec;
    logic [NUM_SLOTS-1:0] flags_q;
    logic [NUM_SLOTS-1:0] en_q;
    logic [NUM_SLOTS-1:0] pend;
    logic [RES_W-1:0]     rd_val;
    logic                 flag_wr;
    logic                 en_wr;

    always_comb begin
        if (bus_addr < FLAG_ADDR)
            acc_kind = ACC_RESULT;
        else if (bus_addr == FLAG_ADDR)
            acc_kind = ACC_FLAG;
        else if (bus_addr == EN_ADDR)
            acc_kind = ACC_ENABLE;
        else
            acc_kind = ACC_NONE;
    end

    always_comb begin
        ld_vec     = ld_en ? (NUM_SLOTS'(1) << ld_slot) : '0;
        rd_clr_vec = '0;
        flag_wr    = 1'b0;
        en_wr      = 1'b0;
        bus_rdata  = '0;
        if (bus_sel) begin
            unique case (acc_kind)
                ACC_RESULT: begin
                    if (!bus_wr) begin
                        rd_clr_vec = NUM_SLOTS'(1) << bus_addr[SLOT_W-1:0];
                        bus_rdata  = DATA_W'(rd_val);
                    end
                end
                ACC_FLAG: begin
                    flag_wr = bus_wr;
                    if (!bus_wr)
                        bus_rdata = DATA_W'(flags_q);
                end
                ACC_ENABLE: begin
                    en_wr = bus_wr;
                    if (!bus_wr)
                        bus_rdata = DATA_W'(en_q);
                end
                ACC_NONE: bus_rdata = '0;
            endcase
        end
    end

    crb_slot_store #(.NUM_SLOTS(NUM_SLOTS), .RES_W(RES_W)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_vec  (ld_vec),
        .ld_data (ld_data),
        .rd_slot (bus_addr[SLOT_W-1:0]),
        .rd_val  (rd_val)
    );

    crb_flag_ctrl #(.NUM_SLOTS(NUM_SLOTS)) flags_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_vec     (ld_vec),
        .rd_clr_vec (rd_clr_vec),
        .flag_wr    (flag_wr),
        .en_wr      (en_wr),
        .wr_val     (bus_wdata[NUM_SLOTS-1:0]),
        .flags_q    (flags_q),
        .en_q       (en_q)
    );

    assign pend = flags_q & en_q;
    assign irq  = |pend;

    crb_prio_idx #(.NUM_SLOTS(NUM_SLOTS)) prio_i (
        .pend (pend),
        .idx  (irq_idx)
    );

    AST_IRQ_MATCHES_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (irq_idx != '0)); // R8

    AST_IDX_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_idx != '0) |-> (flags_q[irq_idx - 1'b1] && en_q[irq_idx - 1'b1])); // R8

    AST_RESULT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && acc_kind == ACC_RESULT) |=> ($stable(en_q))); // R9
endmodule

// File: tb/conv_result_bank_tb.sv
module conv_result_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [3:0]  ld_slot = '0;
    logic [11:0] ld_data = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;
    logic [4:0]  irq_idx;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    conv_result_bank dut_i (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_slot(ld_slot), .ld_data(ld_data),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .irq_idx(irq_idx)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One clock cycle: optional bus access and optional load; returns read data sampled mid-cycle.
    task automatic cyc(input bit sel, input bit wr, input int addr, input int wdata,
                       input bit ld, input int slot, input int data, output int rd);
        @(negedge clk);
        bus_sel = sel; bus_wr = wr; bus_addr = 5'(addr); bus_wdata = 16'(wdata);
        ld_en = ld; ld_slot = 4'(slot); ld_data = 12'(data);
        #2 rd = int'(bus_rdata);
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0; ld_en = 1'b0;
    endtask

    task automatic rd(input int addr, output int v);
        cyc(1, 0, addr, 0, 0, 0, 0, v);
    endtask

    task automatic wr(input int addr, input int v);
        int d;
        cyc(1, 1, addr, v, 0, 0, 0, d);
    endtask

    task automatic ld(input int slot, input int v);
        int d;
        cyc(0, 0, 0, 0, 1, slot, v, d);
    endtask

    task automatic t_reset();
        int v;
        rd(16, v); check("R1 flags", v, 0);
        rd(17, v); check("R1 enables", v, 0);
        rd(5, v);  check("R1 result", v, 0);
        check("R1 irq", int'(irq), 0);
        check("R1 idx", int'(irq_idx), 0);
    endtask

    task automatic t_load_read();
        int v;
        ld(3, 'hABC);
        rd(16, v); check("R3 flag set", v, 'h0008);
        rd(3, v);  check("R2 result", v, 'h0ABC);
        rd(16, v); check("R4 read clears", v, 0);
        ld(15, 'hFFF);
        rd(15, v); check("R2 zero upper", v, 'h0FFF);
        ld(15, 'h001);
        rd(16, v); check("R4 flag read keeps", v, 'h8000);
        rd(17, v);
        rd(16, v); check("R4 enable read keeps", v, 'h8000);
        rd(15, v); check("R2 reload", v, 'h0001);
        rd(16, v); check("R4 cleared", v, 0);
    endtask

    task automatic t_same_cycle();
        int v;
        ld(7, 'h111);
        rd(7, v);
        cyc(1, 0, 7, 0, 1, 7, 'h222, v);
        check("R5 old value", v, 'h111);
        rd(16, v); check("R5 flag kept", v, 'h0080);
        rd(7, v);  check("R5 new value", v, 'h222);
        rd(16, v); check("R5 then cleared", v, 0);
    endtask

    task automatic t_flag_write();
        int v;
        ld(1, 1); ld(2, 2);
        cyc(1, 1, 16, 'h8001, 1, 4, 'h44, v);
        rd(16, v); check("R6 replace plus load", v, 'h8011);
        wr(16, 0);
        rd(16, v); check("R6 write zero", v, 0);
    endtask

    task automatic t_irq();
        int v;
        ld(9, 'h99);
        @(negedge clk);
        check("R7 masked irq", int'(irq), 0);
        check("R8 masked idx", int'(irq_idx), 0);
        wr(17, 'h0200);
        @(negedge clk);
        check("R7 irq on", int'(irq), 1);
        check("R8 idx slot9", int'(irq_idx), 10);
        ld(2, 'h22);
        @(negedge clk);
        check("R8 idx still 9 (2 masked)", int'(irq_idx), 10);
        wr(17, 'h0204);
        @(negedge clk);
        check("R8 lowest slot2", int'(irq_idx), 3);
        rd(2, v);
        @(negedge clk);
        check("R8 back to slot9", int'(irq_idx), 10);
        rd(9, v);
        @(negedge clk);
        check("R7 irq off", int'(irq), 0);
        check("R8 idx none", int'(irq_idx), 0);
    endtask

    task automatic t_ignored();
        int v;
        ld(6, 'h055);
        rd(6, v);
        wr(6, 'h1234);
        rd(6, v);  check("R9 result write ignored", v, 'h055);
        rd(16, v); check("R9 flag untouched", v, 0);
        for (int a = 18; a < 32; a += 13) begin
            rd(a, v); check("R9 unused addr", v, 0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_load_read();
        t_same_cycle();
        t_flag_write();
        t_irq();
        t_ignored();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hang expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule